// File: doc/BRIEF.md
# Tuner Synthesizer Control Port over I2C

This block is the serial control front end of a frequency-synthesizer tuner. A bus master programs the main and swallow counter ratios, the reference divider select, the prescaler halving mode, the charge-pump current, the tuning-voltage disable and four general output ports. It reads back one status byte that carries a power-on flag, the loop lock indication and a 3-bit code from an external level quantizer.

Every data byte names its own type through its top bit. A top bit of 0 opens a two-byte divider group. A top bit of 1 opens a two-byte control group. The divider pair is committed as one unit, so a write that stops after its first divider byte leaves every output as it was. Each control byte commits on its own. Once control data is in place, a short write of address plus two divider bytes is enough to retune.

SCL and SDA are sampled on a fast system clock. SDA is driven only by an open-drain pull-down enable. The two low address bits come from a strap input.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The device address is the 7-bit value {1,1,0,0,0,addr_sel_i[1],addr_sel_i[0]}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low in the ninth clock.
- R2: After a non-matching address the slave gives no acknowledge. It then ignores all bus traffic, and changes no output, until the next START.
- R3: Every data byte of an addressed write is acknowledged.
- R4: A data byte with bit 7 = 0 holds bits 6:0 as main_div_o[10:4]. The byte after it supplies main_div_o[3:0] in bits 7:4 and swallow_o in bits 3:0. Both bytes update the outputs together, in the cycle after the second byte completes.
- R5: A data byte with bit 7 = 1 applies these fields at once: bit 6 to main_div_o[12], bit 5 to main_div_o[11], bit 4 to pre_half_o, and bits 3:0 to ref_sel_o.
- R6: The byte after a control byte of R5 applies these fields at once: bit 7 to vt_off_o, bit 6 to cp_hi_o, and bits 3:0 to port_o. Bits 5:4 are ignored.
- R7: A transfer that ends part-way through a divider pair leaves all outputs unchanged. A 3-byte write of address plus divider pair changes only main_div_o[10:0] and swallow_o.
- R8: A repeated START followed by an address is accepted without a STOP. It discards any unfinished divider pair.
- R9: The read status byte is {por_flag, lock_i, 1, 1, 1, adc_code_i[2:0]}, sent MSB first. Further bytes are sent while the master acknowledges.
- R10: The power-on flag is 1 after reset. It clears when a status byte has been fully sent, so the next status byte reports 0.
- R11: Reset clears every divider and control output to 0 and releases SDA.
- R12: SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel_i | input | 2 | Strap for the two low address bits |
| lock_i | input | 1 | Loop lock indication |
| adc_code_i | input | 3 | Quantized level code |
| main_div_o | output | 13 | Main counter ratio |
| swallow_o | output | 4 | Swallow counter ratio |
| pre_half_o | output | 1 | Prescaler halving enable |
| ref_sel_o | output | 4 | Reference divider select |
| vt_off_o | output | 1 | Tuning voltage output disable |
| cp_hi_o | output | 1 | Charge-pump current select |
| port_o | output | 4 | General output ports |

## Verification
- **When a pin edge takes effect:** an edge on a bus pin reaches the state machine three system clocks later, two for synchronization and one for edge detection.
- **Acknowledge and read data:** the acknowledge or read bit drive follows an SCL falling edge by that same latency.
- **Register updates:** the field registers change one clock later still, about four cycles after the eighth SCL falling edge of a byte.
- **How the bench samples:** a behavioural model updates its expected fields at the end of each acknowledged byte's ninth clock. The bench compares all outputs against this model on every clock. The comparison is masked from the start of a data byte until its acknowledge clock has finished. SDA is sampled in the middle of each SCL high phase, tens of cycles after any drive change.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;

  typedef enum logic [1:0] {SEQ_ANY, SEQ_DIV2, SEQ_CTL2} seq_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import tuner_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              frame_start_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              status_sent_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, oe_q, wr_valid_q, sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      wr_valid_q <= 1'b0;
      sent_q     <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      sent_q     <= 1'b0;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (st_q == ST_WR) begin
                wr_valid_q <= 1'b1;
                oe_q       <= 1'b1;
                st_q       <= ST_WR_ACK;
              end else if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
                rw_q <= sh_q[0];
                oe_q <= 1'b1;
                st_q <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_fall_i) begin
              if (st_q == ST_ADDR_ACK && rw_q) begin
                sh_q <= status_i;
                oe_q <= ~status_i[BYTE_W-1];
                st_q <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                oe_q   <= 1'b0;
                sent_q <= 1'b1;
                st_q   <= ST_RD_ACK;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i && sda_i) begin
              st_q <= ST_IDLE;
            end else if (scl_fall_i) begin
              sh_q <= status_i;
              oe_q <= ~status_i[BYTE_W-1];
              st_q <= ST_RD;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o      = oe_q;
  assign frame_start_o = start_i;
  assign wr_valid_o    = wr_valid_q;
  assign wr_data_o     = sh_q;
  assign status_sent_o = sent_q;

  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);
  // R3
  oe_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (st_q inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD}));
  // R2
  nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && scl_fall_i && cnt_q == CNT_FULL && !start_i && !stop_i
     && sh_q[BYTE_W-1:1] != dev_addr_i) |=> (!oe_q && st_q == ST_IDLE));
endmodule

// File: rtl/tuner_field_bank.sv
module tuner_field_bank
  import tuner_i2c_pkg::*;
#(
  parameter int MDIV_W = 13,
  parameter int SW_W   = 4,
  parameter int REF_W  = 4,
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [MDIV_W-1:0] main_div_o,
  output logic [SW_W-1:0]   swallow_o,
  output logic              pre_half_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              vt_off_o,
  output logic              cp_hi_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int HOLD_W = BYTE_W - 1;
  localparam int LOW_W  = MDIV_W - 2;

  seq_e              seq_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_ANY;
      hold_q     <= '0;
      main_div_o <= '0;
      swallow_o  <= '0;
      pre_half_o <= 1'b0;
      ref_sel_o  <= '0;
      vt_off_o   <= 1'b0;
      cp_hi_o    <= 1'b0;
      port_o     <= '0;
    end else if (frame_start_i) begin
      seq_q <= SEQ_ANY;
    end else if (wr_valid_i) begin
      case (seq_q)
        SEQ_ANY: begin
          if (wr_data_i[BYTE_W-1]) begin
            main_div_o[MDIV_W-1:LOW_W] <= wr_data_i[6:5];
            pre_half_o                 <= wr_data_i[4];
            ref_sel_o                  <= wr_data_i[REF_W-1:0];
            seq_q                      <= SEQ_CTL2;
          end else begin
            hold_q <= wr_data_i[HOLD_W-1:0];
            seq_q  <= SEQ_DIV2;
          end
        end
        SEQ_DIV2: begin
          main_div_o[LOW_W-1:0] <= {hold_q, wr_data_i[7:4]};
          swallow_o             <= wr_data_i[SW_W-1:0];
          seq_q                 <= SEQ_ANY;
        end
        SEQ_CTL2: begin
          vt_off_o <= wr_data_i[7];
          cp_hi_o  <= wr_data_i[6];
          port_o   <= wr_data_i[PORT_W-1:0];
          seq_q    <= SEQ_ANY;
        end
        default: seq_q <= SEQ_ANY;
      endcase
    end
  end

  // R4
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_valid_i) |-> ($stable(main_div_o) && $stable(swallow_o)));
  // R5
  ctl1_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !frame_start_i && seq_q == SEQ_ANY && wr_data_i[BYTE_W-1])
    |=> (ref_sel_o == $past(wr_data_i[REF_W-1:0]) && pre_half_o == $past(wr_data_i[4])));
  // R6
  ctl2_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !frame_start_i && seq_q == SEQ_CTL2)
    |=> (port_o == $past(wr_data_i[PORT_W-1:0]) && vt_off_o == $past(wr_data_i[7])));
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MDIV_W      = 13,
  parameter int SW_W        = 4,
  parameter int REF_W       = 4,
  parameter int PORT_W      = 4,
  parameter int ADC_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [ADC_W-1:0]  adc_code_i,
  output logic [MDIV_W-1:0] main_div_o,
  output logic [SW_W-1:0]   swallow_o,
  output logic              pre_half_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              vt_off_o,
  output logic              cp_hi_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int FILL_W = BYTE_W - 2 - ADC_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic frame_start, wr_valid, status_sent, pr_q;
  logic [BYTE_W-1:0] wr_data, status;

  assign status = {pr_q, lock_i, {FILL_W{1'b1}}, adc_code_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pr_q <= 1'b1;
    else if (status_sent) pr_q <= 1'b0;
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  i2c_byte_engine u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
    .dev_addr_i({ADDR_FIXED, addr_sel_i}), .status_i(status),
    .sda_oe_o(sda_oe_o), .frame_start_o(frame_start), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .status_sent_o(status_sent)
  );

  tuner_field_bank #(
    .MDIV_W(MDIV_W), .SW_W(SW_W), .REF_W(REF_W), .PORT_W(PORT_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .main_div_o(main_div_o), .swallow_o(swallow_o), .pre_half_o(pre_half_o),
    .ref_sel_o(ref_sel_o), .vt_off_o(vt_off_o), .cp_hi_o(cp_hi_o), .port_o(port_o)
  );

  // R10
  pr_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(pr_q));
  // R10
  pr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_sent |=> !pr_q);
endmodule

// File: tb/tuner_i2c_slave_tb.sv
`timescale 1ns/1ps
module tuner_i2c_slave_tb_top;
  localparam int Q = 20;
  localparam int WDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic lock = 1'b1;
  logic [2:0] adc = 3'b101;
  logic sda_oe, sda_line;
  logic [12:0] main_div;
  logic [3:0] swallow, ref_sel, port;
  logic pre_half, vt_off, cp_hi;

  int checks = 0, fails = 0, cycles = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R11";

  // behavioural expectation
  logic [12:0] e_div = '0;
  logic [3:0] e_sw = '0, e_ref = '0, e_port = '0;
  logic e_pe = 0, e_os = 0, e_cp = 0;
  int phase = 0;
  logic [6:0] pend = '0;

  assign sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  tuner_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(strap), .lock_i(lock), .adc_code_i(adc),
    .main_div_o(main_div), .swallow_o(swallow), .pre_half_o(pre_half),
    .ref_sel_o(ref_sel), .vt_off_o(vt_off), .cp_hi_o(cp_hi), .port_o(port)
  );

  function automatic logic [27:0] act_vec();
    return {main_div, swallow, pre_half, ref_sel, vt_off, cp_hi, port};
  endfunction
  function automatic logic [27:0] exp_vec();
    return {e_div, e_sw, e_pe, e_ref, e_os, e_cp, e_port};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      checks++;
      if (act_vec() !== exp_vec()) begin
        fails++;
        $display("FAIL %s fields actual=0x%0h expected=0x%0h", cur_req, act_vec(), exp_vec());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic model_apply(input logic [7:0] b);
    case (phase)
      0: if (b[7]) begin
           e_div[12] = b[6]; e_div[11] = b[5]; e_pe = b[4]; e_ref = b[3:0]; phase = 2;
         end else begin
           pend = b[6:0]; phase = 1;
         end
      1: begin e_div[10:0] = {pend, b[7:4]}; e_sw = b[3:0]; phase = 0; end
      default: begin e_os = b[7]; e_cp = b[6]; e_port = b[3:0]; phase = 0; end
    endcase
  endtask

  task automatic bstart();
    m_sda = 1; wq(); scl = 1; wq(); m_sda = 0; wq(); scl = 0; wq();
    phase = 0;
  endtask

  task automatic bstop();
    m_sda = 0; wq(); scl = 1; wq(); m_sda = 1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, input bit exp_ack, input bit is_data, input string req);
    logic got;
    if (is_data) cmp_en = 0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; wq(); scl = 1; wq();
    got = ~sda_line;
    chk(req, got, exp_ack);
    wq(); scl = 0; wq();
    if (is_data && got) model_apply(b);
    cmp_en = 1;
  endtask

  task automatic rbyte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1; wq(); scl = 1; wq(); v = {v[6:0], sda_line}; wq(); scl = 0; wq();
    end
    chk(req, v, exp);
    send_bit(mack ? 1'b0 : 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11", act_vec(), 0);
    chk("R11", sda_oe, 0);
    cmp_en = 1;

    // R9 R10 first status read, PR set then cleared within the same transfer
    cur_req = "R2";
    bstart();
    wbyte(8'hC5, 1, 0, "R1");
    rbyte(8'hFD, 1, "R10");
    rbyte(8'h7D, 0, "R10");
    bstop();

    // R4 R5 R6 full write
    cur_req = "R4";
    bstart();
    wbyte(8'hC4, 1, 0, "R1");
    wbyte(8'hD5, 1, 1, "R3");
    wbyte(8'h8A, 1, 1, "R3");
    wbyte(8'h5A, 1, 1, "R3");
    wbyte(8'h3C, 1, 1, "R3");
    bstop();
    chk("R4", main_div, 13'h15A3);
    chk("R4", swallow, 4'hC);
    chk("R5", {pre_half, ref_sel}, 5'h15);
    chk("R6", {vt_off, cp_hi, port}, 6'h2A);

    // R7 partial divider write then 3-byte write
    cur_req = "R7";
    bstart();
    wbyte(8'hC4, 1, 0, "R1");
    wbyte(8'h01, 1, 1, "R3");
    bstop();
    chk("R7", main_div, 13'h15A3);
    bstart();
    wbyte(8'hC4, 1, 0, "R1");
    wbyte(8'h12, 1, 1, "R3");
    wbyte(8'h34, 1, 1, "R3");
    bstop();
    chk("R7", main_div, 13'h1123);
    chk("R7", swallow, 4'h4);

    // R2 foreign address ignored until START
    cur_req = "R2";
    bstart();
    wbyte(8'hC8, 0, 0, "R2");
    wbyte(8'h00, 0, 0, "R2");
    wbyte(8'hFF, 0, 0, "R2");
    bstop();
    chk("R2", main_div, 13'h1123);

    // R8 repeated start
    cur_req = "R8";
    bstart();
    wbyte(8'hC4, 1, 0, "R1");
    wbyte(8'hA3, 1, 1, "R5");
    bstart();
    wbyte(8'hC4, 1, 0, "R8");
    wbyte(8'h7F, 1, 1, "R3");
    bstart();
    wbyte(8'hC4, 1, 0, "R8");
    wbyte(8'h11, 1, 1, "R8");
    wbyte(8'h22, 1, 1, "R8");
    bstop();
    chk("R8", main_div, 13'h0912);
    chk("R5", ref_sel, 4'h3);

    // R6 control pair, ignored bits 5:4
    cur_req = "R6";
    bstart();
    wbyte(8'hC4, 1, 0, "R1");
    wbyte(8'h80, 1, 1, "R5");
    wbyte(8'h7F, 1, 1, "R6");
    bstop();
    chk("R6", {vt_off, cp_hi, port}, 6'h1F);
    chk("R5", {main_div[12:11], pre_half, ref_sel}, 0);

    // R1 other strap, R9 status contents
    cur_req = "R9";
    strap = 2'b01; lock = 0; adc = 3'b010;
    wq();
    bstart();
    wbyte(8'hC5, 0, 0, "R1");
    bstop();
    bstart();
    wbyte(8'hC3, 1, 0, "R1");
    rbyte(8'h3A, 0, "R9");
    bstop();
    bstart();
    wbyte(8'hC2, 1, 0, "R1");
    wbyte(8'hF6, 1, 1, "R5");
    bstop();
    chk("R5", {main_div[12:11], pre_half, ref_sel}, 7'h76);

    wq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule